// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight token flags that two independent processors share, one attached to a left port and one to a right port. A processor claims a token by writing a zero to its slot, then reads the slot back. A zero in the readback means the claim succeeded. A one means the token belongs to the other side. Writing a one hands the token back, or withdraws a claim that is still waiting. Software builds its own locking protocol on these flags, for example to decide which side may touch a region of a shared memory.

Both ports share one clock. Each slot is a small state machine with five named states. `S_FREE` means no owner. `S_LEFT` and `S_RIGHT` mean one side owns the token and nothing waits. `S_LEFT_RW` means the left side owns it and the right side's claim is latched. `S_RIGHT_LW` is the mirror of that.

The slot state changes as follows:
- From `S_FREE`: a lone claim moves to that side's owned state. Two claims in the same cycle go to the side chosen by a global toggle bit, and the loser is latched as pending.
- From an owned state: the owner's release moves to `S_FREE`. If the other side claims in the same cycle, the token moves straight to the other side instead. A claim from the other side on its own moves to the pending state.
- From a pending state: the owner's release passes the token to the waiting side. The waiting side's release withdraws its claim and returns to the owned state. Releases from both sides in the same cycle move to `S_FREE`.

Reset places every slot in `S_LEFT_RW`. A slot therefore becomes free only after both sides have written a one to it.

Top module: `sem_bank`

## Requirements
- R1: There are eight slots, addressed by the 3-bit index. An operation on one slot never changes the state or the readback of any other slot, and one side may own one slot while it waits on another.
- R2: A write of 0 (`din`=0) to an `S_FREE` slot with no competing claim makes the writer the owner. A read strobe in cycle N makes `dout` valid after the edge that ends cycle N, and it returns 0 while the reader owns the slot. `dout` reflects the state before any write made in the same cycle, and it holds its value between reads.
- R3: The readback is 1 when the reader does not own the slot: the slot is free, the other side owns it, or the reader is only pending. Both `dout` outputs are 1 after reset.
- R4: A claim on a slot that the other side owns is latched as pending. When the owner writes 1, the waiting side becomes the owner on that clock edge. If the owner releases and the other side claims in the same cycle, the other side becomes the owner directly.
- R5: A write of 1 by a side that is pending withdraws its claim. A later release by the owner then leaves the slot free.
- R6: A write of 1 by a side that neither owns nor waits on the slot changes nothing. A write of 0 by the current owner also changes nothing.
- R7: Two claims on the same `S_FREE` slot in the same cycle grant exactly one side, and the loser is latched as pending. The first such tie after reset goes to the left side. Priority then alternates after every tie.
- R8: After reset every slot is owned by the left side with the right side pending. A slot becomes free only after both sides write 1 to it, in either order.
- R9: Two reads of the same slot in the same cycle never both return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_idx | input | 3 | Left slot index |
| l_din | input | 1 | Left write data (0 claim, 1 release) |
| l_dout | output | 1 | Left registered readback (0 = owned by left) |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_idx | input | 3 | Right slot index |
| r_din | input | 1 | Right write data (0 claim, 1 release) |
| r_dout | output | 1 | Right registered readback (0 = owned by right) |

## Verification
The bench first frees every slot from its reset state, using both release orders. This separates a pending-side withdrawal from an owner hand-off. It then drives a lone claim, a claim against an owned slot, and a release made together with a competing claim. Separate cases cover foreign and duplicate writes, which must leave readback unchanged, and a withdrawal, which must stop a later hand-off. Three same-cycle ties on free slots show whether priority really alternates or stays fixed. Reads on neighbouring slots while others change show that the slots stay independent.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int SW = 3;

    typedef enum logic [SW-1:0] {
        S_FREE     = 3'd0,
        S_LEFT     = 3'd1,
        S_RIGHT    = 3'd2,
        S_LEFT_RW  = 3'd3,
        S_RIGHT_LW = 3'd4
    } sem_state_t;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       l_claim,
    input  logic       l_rel,
    input  logic       r_claim,
    input  logic       r_rel,
    input  logic       prio_right,
    output sem_state_t st_o,
    output logic       tie_o
);
    sem_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_LEFT_RW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d  = st_q;
        tie_o = 1'b0;
        unique case (st_q)
            S_FREE: begin
                if (l_claim && r_claim) begin
                    tie_o = 1'b1;
                    st_d  = prio_right ? S_RIGHT_LW : S_LEFT_RW;
                end else if (l_claim) st_d = S_LEFT;
                else if (r_claim)     st_d = S_RIGHT;
            end
            S_LEFT: begin
                if (l_rel)        st_d = r_claim ? S_RIGHT : S_FREE;
                else if (r_claim) st_d = S_LEFT_RW;
            end
            S_RIGHT: begin
                if (r_rel)        st_d = l_claim ? S_LEFT : S_FREE;
                else if (l_claim) st_d = S_RIGHT_LW;
            end
            S_LEFT_RW: begin
                if (l_rel && r_rel) st_d = S_FREE;
                else if (l_rel)     st_d = S_RIGHT;
                else if (r_rel)     st_d = S_LEFT;
            end
            S_RIGHT_LW: begin
                if (l_rel && r_rel) st_d = S_FREE;
                else if (r_rel)     st_d = S_LEFT;
                else if (l_rel)     st_d = S_RIGHT;
            end
            default: st_d = S_FREE;
        endcase
    end

    assign st_o = st_q;
endmodule

// File: rtl/sem_readport.sv
module sem_readport
    import sem_pkg::*;
#(
    parameter int NSEM  = 8,
    parameter bit RIGHT = 1'b0,
    localparam int IW   = $clog2(NSEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IW-1:0]      idx,
    input  logic [NSEM*SW-1:0] st_flat,
    output logic               dout
);
    logic [SW-1:0] cur;
    logic          mine;

    always_comb begin
        cur = st_flat[idx*SW +: SW];
        if (RIGHT) mine = (cur == S_RIGHT) || (cur == S_RIGHT_LW);
        else       mine = (cur == S_LEFT)  || (cur == S_LEFT_RW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= 1'b1;
        else if (rd_en) dout <= ~mine;
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NSEM = 8,
    localparam int IW  = $clog2(NSEM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [IW-1:0] l_idx,
    input  logic          l_din,
    output logic          l_dout,
    input  logic          r_sel,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic [IW-1:0] r_idx,
    input  logic          r_din,
    output logic          r_dout
);
    logic [NSEM*SW-1:0] st_flat;
    logic [NSEM-1:0]    tie;
    logic               prio_q;
    sem_state_t         cell_st [NSEM];

    wire l_w0 = l_sel && l_wr && !l_din;
    wire l_w1 = l_sel && l_wr &&  l_din;
    wire r_w0 = r_sel && r_wr && !r_din;
    wire r_w1 = r_sel && r_wr &&  r_din;

    for (genvar i = 0; i < NSEM; i++) begin : g_cell
        wire l_hit = (l_idx == IW'(i));
        wire r_hit = (r_idx == IW'(i));
        sem_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .l_claim   (l_w0 && l_hit),
            .l_rel     (l_w1 && l_hit),
            .r_claim   (r_w0 && r_hit),
            .r_rel     (r_w1 && r_hit),
            .prio_right(prio_q),
            .st_o      (cell_st[i]),
            .tie_o     (tie[i])
        );
        assign st_flat[i*SW +: SW] = cell_st[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  prio_q <= 1'b0;
        else if (|tie) prio_q <= ~prio_q;
    end

    sem_readport #(.NSEM(NSEM), .RIGHT(1'b0)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_sel && l_rd),
        .idx(l_idx), .st_flat(st_flat), .dout(l_dout)
    );

    sem_readport #(.NSEM(NSEM), .RIGHT(1'b1)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_sel && r_rd),
        .idx(r_idx), .st_flat(st_flat), .dout(r_dout)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
#(
    parameter int NSEM = 8,
    localparam int IW  = $clog2(NSEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel, l_wr, l_rd, l_din, l_dout,
    input logic [IW-1:0]      l_idx,
    input logic               r_sel, r_wr, r_rd, r_din, r_dout,
    input logic [IW-1:0]      r_idx,
    input logic [NSEM*SW-1:0] st_flat,
    input logic               prio_q
);
    function automatic logic [SW-1:0] st_at(input logic [IW-1:0] i);
        return st_flat[i*SW +: SW];
    endfunction

    wire lw0 = l_sel && l_wr && !l_din;
    wire lw1 = l_sel && l_wr &&  l_din;
    wire rw0 = r_sel && r_wr && !r_din;
    wire rw1 = r_sel && r_wr &&  r_din;
    wire same = (l_idx == r_idx);

    a_r2_lone_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (lw0 && st_at(l_idx) == S_FREE && !(rw0 && same))
        |=> st_at($past(l_idx)) == S_LEFT);

    a_r2_left_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_rd)
        |=> l_dout == !($past(st_at(l_idx)) == S_LEFT || $past(st_at(l_idx)) == S_LEFT_RW));

    a_r4_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (lw1 && st_at(l_idx) == S_LEFT_RW && !(rw1 && same))
        |=> st_at($past(l_idx)) == S_RIGHT);

    a_r6_foreign_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rw1 && st_at(r_idx) == S_LEFT && !((lw1 || lw0) && same))
        |=> st_at($past(r_idx)) == S_LEFT);

    a_r7_tie_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (lw0 && rw0 && same && st_at(l_idx) == S_FREE)
        |=> st_at($past(l_idx)) == ($past(prio_q) ? S_RIGHT_LW : S_LEFT_RW));

    a_r7_tie_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (lw0 && rw0 && same && st_at(l_idx) == S_FREE)
        |=> prio_q != $past(prio_q));

    a_r9_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_rd && r_sel && r_rd && same)
        |=> !(l_dout == 1'b0 && r_dout == 1'b0));
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_din(l_din), .l_dout(l_dout), .l_idx(l_idx),
    .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_din(r_din), .r_dout(r_dout), .r_idx(r_idx),
    .st_flat(st_flat), .prio_q(prio_q)
);

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    localparam int NOP = 0, WR = 1, RD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_wr = 0, l_rd = 0, l_din = 0;
    logic r_sel = 0, r_wr = 0, r_rd = 0, r_din = 0;
    logic [2:0] l_idx = 0, r_idx = 0;
    logic l_dout, r_dout;

    int checks = 0, fails = 0;
    bit  ql[$], qr[$];
    string tl[$], tr[$];
    bit pend_l = 0, pend_r = 0;

    always #2 clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_din(l_din), .l_dout(l_dout),
        .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_din(r_din), .r_dout(r_dout)
    );

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // monitor: a read issued in one cycle is compared one cycle later
    always @(negedge clk) begin
        if (pend_l && ql.size() > 0) check(tl.pop_front(), l_dout, ql.pop_front());
        if (pend_r && qr.size() > 0) check(tr.pop_front(), r_dout, qr.pop_front());
        pend_l = l_sel && l_rd;
        pend_r = r_sel && r_rd;
    end

    // driver: for RD, d is the expected readback pushed to the scoreboard
    task automatic cyc(input int lop, input int li, input bit ld, input string lt,
                       input int rop, input int ri, input bit rd_, input string rt);
        @(posedge clk); #1;
        l_sel = (lop != NOP); l_wr = (lop == WR); l_rd = (lop == RD);
        l_idx = 3'(li); l_din = (lop == WR) ? ld : 1'b0;
        r_sel = (rop != NOP); r_wr = (rop == WR); r_rd = (rop == RD);
        r_idx = 3'(ri); r_din = (rop == WR) ? rd_ : 1'b0;
        if (lop == RD) begin ql.push_back(ld);  tl.push_back(lt); end
        if (rop == RD) begin qr.push_back(rd_); tr.push_back(rt); end
    endtask

    task automatic lop(input int op, input int i, input bit d, input string t);
        cyc(op, i, d, t, NOP, 0, 0, "");
    endtask
    task automatic rop(input int op, input int i, input bit d, input string t);
        cyc(NOP, 0, 0, "", op, i, d, t);
    endtask

    task automatic run();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset left dout", l_dout, 1'b1);
        check("R3 reset right dout", r_dout, 1'b1);
        // R8: reset state
        cyc(RD, 0, 0, "R8 left owns after reset", RD, 0, 1, "R8 right pending after reset");
        // free slot 0: right withdraws first, then left releases
        rop(WR, 0, 1, "");
        lop(RD, 0, 0, "R8 left still owns after right withdraw");
        lop(WR, 0, 1, "");
        cyc(RD, 0, 1, "R8 slot0 free left", RD, 0, 1, "R8 slot0 free right");
        // slots 1..7: left releases first, token passes to right
        lop(WR, 1, 1, "");
        rop(RD, 1, 0, "R8 right gets slot1 after left release");
        rop(WR, 1, 1, "");
        for (int i = 2; i < 8; i++) begin
            lop(WR, i, 1, "");
            rop(WR, i, 1, "");
        end
        lop(RD, 1, 1, "R8 slot1 free");
        lop(RD, 3, 1, "R3 free slot reads one");
        // R2 lone claim
        lop(WR, 2, 0, "");
        lop(RD, 2, 0, "R2 left owns slot2");
        rop(RD, 2, 1, "R3 right sees slot2 taken");
        lop(RD, 3, 1, "R1 slot3 unaffected");
        // R4 pending then hand-off
        rop(WR, 2, 0, "");
        rop(RD, 2, 1, "R3 pending right reads one");
        lop(WR, 2, 1, "");
        rop(RD, 2, 0, "R4 right gets slot2 on release");
        lop(RD, 2, 1, "R4 left lost slot2");
        // R6 foreign release and duplicate claim
        lop(WR, 2, 1, "");
        rop(RD, 2, 0, "R6 foreign release ignored");
        rop(WR, 2, 0, "");
        rop(RD, 2, 0, "R6 duplicate claim ignored");
        // R5 withdraw
        lop(WR, 2, 0, "");
        lop(WR, 2, 1, "");
        rop(WR, 2, 1, "");
        lop(RD, 2, 1, "R5 withdrawn claim not granted");
        lop(WR, 2, 0, "");
        lop(RD, 2, 0, "R5 slot2 was free after withdraw");
        lop(WR, 2, 1, "");
        // R7 ties: left, right, left
        cyc(WR, 4, 0, "", WR, 4, 0, "");
        cyc(RD, 4, 0, "R7 first tie left wins", RD, 4, 1, "R9 first tie right loses");
        lop(WR, 4, 1, "");
        rop(RD, 4, 0, "R7 tie loser was latched");
        rop(WR, 4, 1, "");
        cyc(WR, 5, 0, "", WR, 5, 0, "");
        cyc(RD, 5, 1, "R7 second tie left loses", RD, 5, 0, "R7 second tie right wins");
        rop(WR, 5, 1, "");
        lop(RD, 5, 0, "R7 left gets slot5 after right release");
        lop(WR, 5, 1, "");
        cyc(WR, 4, 0, "", WR, 4, 0, "");
        cyc(RD, 4, 0, "R7 third tie left wins", RD, 4, 1, "R9 third tie right loses");
        lop(WR, 4, 1, "");
        rop(WR, 4, 1, "");
        // R4 release plus competing claim in the same cycle
        lop(WR, 6, 0, "");
        cyc(WR, 6, 1, "", WR, 6, 0, "");
        cyc(RD, 6, 1, "R4 left gave slot6", RD, 6, 0, "R4 right took slot6 directly");
        // R1 own one slot while waiting on another
        lop(WR, 7, 0, "");
        lop(WR, 6, 0, "");
        lop(RD, 7, 0, "R1 left holds slot7");
        lop(RD, 6, 1, "R1 left pending on slot6");
        rop(WR, 6, 1, "");
        lop(RD, 6, 0, "R1 left gets slot6 while holding slot7");
        cyc(NOP, 0, 0, "", NOP, 0, 0, "");
        repeat (3) @(posedge clk);
    endtask

    initial begin
        bit timeout = 0;
        fork
            run();
            begin repeat (5000) @(posedge clk); timeout = 1; end
        join_any
        disable fork;
        if (timeout) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        if (ql.size() + qr.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", ql.size() + qr.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule